// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a byte-wide flash part. It decides whether a program or erase operation started earlier has finished. After a `start` pulse it reads the device's 8-bit status word through a valid/ready request channel and takes each byte back through a valid/ready response channel. It compares the chosen toggle bit across two back-to-back reads. A bit that holds its value means the operation is complete. A bit that changes means the operation is still running, so the block looks at the timeout flag (bit 5) of the newer read.

When the timeout flag is set, the block does not fail at once. It takes one more pair of reads, because the toggling may have stopped at the same moment the flag rose. If the bit still toggles in that pair, the block writes the reset command so the device returns to array reads, waits for that write to be acknowledged, and then reports failure. If the bit toggles and the timeout flag is clear, the block either polls again with a new pair or gives up the bus when `yield_req` is set. A later `start` always begins again from a fresh pair of reads.

Bus rules: a request stays valid, with address, direction and data held, until `req_ready` accepts it. Only one transfer is outstanding at a time. Every request, whether a read or a write, gets exactly one response beat. `rsp_ready` is high only while a response is owed, so the responder may hold back a response for as long as it needs.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: After reset `busy`, `req_valid`, `rsp_ready`, `done_ok`, `done_fail` and `yielded` are all low.
- R2: A `start` pulse seen while idle raises `busy` in the next cycle and launches a status read. A `start` seen while busy has no effect on the reads issued or on the outcome.
- R3: Each evaluation uses two consecutive status reads at `STATUS_ADDR`. The monitored bit is bit 6 when `bit_sel` is 0 and bit 2 when `bit_sel` is 1. The unselected toggle bit has no effect.
- R4: If the monitored bit is equal in the two reads of the first pair, `done_ok` pulses after exactly two reads and no write is issued.
- R5: If the first pair toggles and bit 5 of its second read is 1, exactly two more reads follow. If these two agree on the monitored bit, `done_ok` pulses.
- R6: If the re-check pair still toggles, a single write of 0xF0 to `RESET_ADDR` is issued, and `done_fail` pulses only in the cycle after that write's response is accepted.
- R7: If a non-recheck pair toggles with bit 5 of its second read at 0, then `yield_req` high at that evaluation returns the block to idle with `yielded` high and no done pulse. With `yield_req` low the block takes a new pair of reads. `yielded` clears on the next `start`, and polling restarts from a new pair.
- R8: `done_ok` and `done_fail` are one-cycle pulses, never high together, and `busy` falls in the cycle one of them (or `yielded`) rises.
- R9: A request is held stable until accepted. At most one transfer is outstanding. `rsp_ready` is high only while a response is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fresh poll (honoured only when idle) |
| yield_req | input | 1 | Give up polling at the next still-running evaluation |
| bit_sel | input | 1 | 0: monitor bit 6, 1: monitor bit 2 |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high with `req_valid` |
| req_write | output | 1 | 1: write, 0: status read |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | 8 | Write data (reset command) |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Block can take the response |
| rsp_data | input | 8 | Status byte returned by a read |
| busy | output | 1 | Poll in progress |
| done_ok | output | 1 | Operation completed pulse |
| done_fail | output | 1 | Operation failed pulse (after reset write) |
| yielded | output | 1 | Poll abandoned by yield, cleared by `start` |

## Verification
The bench builds the block with `ADDR_W` = 4, `STATUS_ADDR` = 5 and `RESET_ADDR` = 10. These values are small enough that any stray address shows up at once, while the status bit positions stay at their defaults. For both values of `bit_sel` it sweeps all 128 combinations of the monitored bit over four scripted reads, the two timeout flags and a noise value on the unselected toggle bit, with yield on and off. Together these reach every path: success on the first pair, success on the re-check, failure with the reset write, polling on, and yield followed by resume. The responder's accept and response delays change from one transfer to the next, so the hold-until-accepted and one-outstanding rules are exercised under back-pressure.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_EVAL,
    ST_WR
  } poll_state_e;
endpackage

// File: rtl/tbp_bus_port.sv
module tbp_bus_port #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] STATUS_ADDR = 16'h0000,
  parameter logic [15:0] RESET_ADDR  = 16'h0000,
  parameter logic [7:0]  RESET_CMD   = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_wr,
  output logic              xfer_done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready
);
  logic vld_q, wr_q, owe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wr_q  <= 1'b0;
      owe_q <= 1'b0;
    end else begin
      if (launch) begin
        vld_q <= 1'b1;
        wr_q  <= launch_wr;
      end else if (vld_q && req_ready) begin
        vld_q <= 1'b0;
        owe_q <= 1'b1;
      end
      if (owe_q && rsp_valid) owe_q <= 1'b0;
    end
  end

  assign req_valid = vld_q;
  assign req_write = wr_q;
  assign req_addr  = wr_q ? RESET_ADDR[ADDR_W-1:0] : STATUS_ADDR[ADDR_W-1:0];
  assign req_wdata = wr_q ? RESET_CMD : 8'h00;
  assign rsp_ready = owe_q;
  assign xfer_done = owe_q && rsp_valid;
endmodule

// File: rtl/tbp_sample_cmp.sv
module tbp_sample_cmp #(
  parameter int POS_A   = 6,
  parameter int POS_B   = 2,
  parameter int POS_TMO = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_sel,
  input  logic       cap_first,
  input  logic       cap_second,
  input  logic [7:0] data,
  output logic       toggled,
  output logic       timeout
);
  logic pick, first_q, second_q, tmo_q;

  assign pick = bit_sel ? data[POS_B] : data[POS_A];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= 1'b0;
      second_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      if (cap_first) first_q <= pick;
      if (cap_second) begin
        second_q <= pick;
        tmo_q    <= data[POS_TMO];
      end
    end
  end

  assign toggled = first_q ^ second_q;
  assign timeout = tmo_q;
endmodule

// File: rtl/tbp_fsm.sv
module tbp_fsm
  import tbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic yield_req,
  input  logic xfer_done,
  input  logic toggled,
  input  logic timeout,
  output logic launch,
  output logic launch_wr,
  output logic cap_first,
  output logic cap_second,
  output logic busy,
  output logic done_ok,
  output logic done_fail,
  output logic yielded
);
  poll_state_e st_q, st_d;
  logic recheck_q, recheck_d;
  logic ok_d, fail_d, yld_d;

  always_comb begin
    st_d       = st_q;
    recheck_d  = recheck_q;
    launch     = 1'b0;
    launch_wr  = 1'b0;
    cap_first  = 1'b0;
    cap_second = 1'b0;
    ok_d       = 1'b0;
    fail_d     = 1'b0;
    yld_d      = yielded;
    unique case (st_q)
      ST_IDLE: if (start) begin
        launch    = 1'b1;
        recheck_d = 1'b0;
        yld_d     = 1'b0;
        st_d      = ST_RD_A;
      end
      ST_RD_A: if (xfer_done) begin
        cap_first = 1'b1;
        launch    = 1'b1;
        st_d      = ST_RD_B;
      end
      ST_RD_B: if (xfer_done) begin
        cap_second = 1'b1;
        st_d       = ST_EVAL;
      end
      ST_EVAL: begin
        if (!toggled) begin
          ok_d = 1'b1;
          st_d = ST_IDLE;
        end else if (recheck_q) begin
          launch    = 1'b1;
          launch_wr = 1'b1;
          st_d      = ST_WR;
        end else if (timeout) begin
          recheck_d = 1'b1;
          launch    = 1'b1;
          st_d      = ST_RD_A;
        end else if (yield_req) begin
          yld_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          launch = 1'b1;
          st_d   = ST_RD_A;
        end
      end
      ST_WR: if (xfer_done) begin
        fail_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      recheck_q <= 1'b0;
      done_ok   <= 1'b0;
      done_fail <= 1'b0;
      yielded   <= 1'b0;
    end else begin
      st_q      <= st_d;
      recheck_q <= recheck_d;
      done_ok   <= ok_d;
      done_fail <= fail_d;
      yielded   <= yld_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/tbp_poll_ctrl.sv
module tbp_poll_ctrl #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] STATUS_ADDR = 16'h0000,
  parameter logic [15:0] RESET_ADDR  = 16'h0000,
  parameter logic [7:0]  RESET_CMD   = 8'hF0,
  parameter int          POS_A       = 6,
  parameter int          POS_B       = 2,
  parameter int          POS_TMO     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              yield_req,
  input  logic              bit_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  output logic              busy,
  output logic              done_ok,
  output logic              done_fail,
  output logic              yielded
);
  logic launch, launch_wr, xfer_done, cap_first, cap_second, toggled, timeout;

  tbp_bus_port #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
    .RESET_ADDR(RESET_ADDR), .RESET_CMD(RESET_CMD)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_wr(launch_wr),
    .xfer_done(xfer_done), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready)
  );

  tbp_sample_cmp #(.POS_A(POS_A), .POS_B(POS_B), .POS_TMO(POS_TMO)) u_cmp (
    .clk(clk), .rst_n(rst_n), .bit_sel(bit_sel),
    .cap_first(cap_first), .cap_second(cap_second),
    .data(rsp_data), .toggled(toggled), .timeout(timeout)
  );

  tbp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .yield_req(yield_req),
    .xfer_done(xfer_done), .toggled(toggled), .timeout(timeout),
    .launch(launch), .launch_wr(launch_wr), .cap_first(cap_first),
    .cap_second(cap_second), .busy(busy), .done_ok(done_ok),
    .done_fail(done_fail), .yielded(yielded)
  );
endmodule

// File: rtl/tbp_poll_chk.sv
module tbp_poll_chk #(
  parameter logic [7:0] RESET_CMD = 8'hF0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [7:0] req_wdata,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       busy,
  input logic       done_ok,
  input logic       done_fail,
  input logic       yielded
);
  logic owe_q, wr_owe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owe_q    <= 1'b0;
      wr_owe_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        owe_q    <= 1'b1;
        wr_owe_q <= req_write;
      end else if (rsp_valid && rsp_ready) begin
        owe_q    <= 1'b0;
        wr_owe_q <= 1'b0;
      end
    end
  end

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_wr_is_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> req_wdata == RESET_CMD);
  assert_fail_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |-> $past(wr_owe_q && rsp_valid && rsp_ready));
  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_fail));
  assert_ok_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !done_ok);
  assert_fail_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |=> !done_fail);
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_ok || done_fail || $rose(yielded)));
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) && $stable(req_wdata)));
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    owe_q |-> !req_valid);
  assert_rsp_ready_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> owe_q);
endmodule

bind tbp_poll_ctrl tbp_poll_chk #(.RESET_CMD(RESET_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .busy(busy),
  .done_ok(done_ok), .done_fail(done_fail), .yielded(yielded)
);

// File: tb/tb_tbp_poll_ctrl.sv
module tb_tbp_poll_ctrl;
  localparam int AW = 4;
  localparam logic [3:0] ST_A = 4'h5;
  localparam logic [3:0] RS_A = 4'hA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, yield_req = 1'b0, bit_sel = 1'b0;
  logic req_valid, req_write, rsp_ready, busy, done_ok, done_fail, yielded;
  logic [AW-1:0] req_addr;
  logic [7:0] req_wdata;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;

  int tests = 0, fails = 0;
  int nread = 0, nwrite = 0, nbad = 0;
  logic [7:0] last_wdata = 8'h00;
  logic [3:0] last_waddr = 4'h0;
  int run_base = 0, cur_pat = 0;
  bit s_busy = 0;
  int s_wait = 0;

  always #10 clk = ~clk;

  tbp_poll_ctrl #(.ADDR_W(AW), .STATUS_ADDR(16'h5), .RESET_ADDR(16'hA)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .yield_req(yield_req), .bit_sel(bit_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .busy(busy), .done_ok(done_ok),
    .done_fail(done_fail), .yielded(yielded)
  );

  function automatic logic [7:0] status_byte(input int pat, input bit sel, input int k);
    logic [7:0] b = 8'h00;
    if (k < 4) begin
      b[sel ? 2 : 6] = pat[k];
      b[sel ? 6 : 2] = pat[6] ^ k[0];
      if (k == 1) b[5] = pat[4];
      if (k == 3) b[5] = pat[5];
      b[0] = k[0];
    end
    return b;
  endfunction

  // res: 0 ok first pair, 1 ok after recheck, 2 fail, 3 yielded
  task automatic model(input int pat, input bit sel, input int k0, input bit yld,
                       output int res, output int k_end);
    int k = k0;
    bit rc = 0;
    res = -1;
    while (res < 0) begin
      logic [7:0] a = status_byte(pat, sel, k);
      logic [7:0] b = status_byte(pat, sel, k + 1);
      int p = sel ? 2 : 6;
      k += 2;
      if (a[p] == b[p]) res = rc ? 1 : 0;
      else if (rc) res = 2;
      else if (b[5]) rc = 1;
      else if (yld) res = 3;
    end
    k_end = k;
  endtask

  // responder with changing accept and response delays
  always @(posedge clk) begin
    if (!rst_n) begin
      req_ready <= 1'b0; rsp_valid <= 1'b0; s_busy <= 0; s_wait <= 0;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0; s_busy <= 0; s_wait <= nread % 2;
    end else if (s_busy) begin
      if (!rsp_valid) begin
        if (s_wait == 0) rsp_valid <= 1'b1; else s_wait <= s_wait - 1;
      end
    end else if (req_valid && req_ready) begin
      req_ready <= 1'b0; s_busy <= 1; s_wait <= (nread + nwrite) % 3;
      if (req_write) begin
        nwrite <= nwrite + 1; last_wdata <= req_wdata; last_waddr <= req_addr;
        rsp_data <= 8'h00;
        if (req_addr != RS_A) nbad <= nbad + 1;
      end else begin
        nread <= nread + 1;
        rsp_data <= status_byte(cur_pat, bit_sel, nread - run_base);
        if (req_addr != ST_A) nbad <= nbad + 1;
      end
    end else if (s_wait > 0) begin
      s_wait <= s_wait - 1;
    end else begin
      req_ready <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one poll from start to end; extra_start pulses start again mid-poll
  task automatic one_poll(input int pat, input bit sel, input int k0, input bit yld,
                          input bit extra_start, output int k_end);
    int res, r0, w0, b0, cyc;
    model(pat, sel, k0, yld, res, k_end);
    @(negedge clk);
    r0 = nread; w0 = nwrite; b0 = nbad;
    yield_req = yld;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", busy, 1);
    cyc = 0;
    while (busy && cyc < 400) begin
      if (extra_start && cyc == 3) start = 1'b1; else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(res == 3 ? (yielded && !done_ok && !done_fail) : 1'b1, "R7 yield outcome",
          {yielded, done_ok, done_fail}, 4);
    check(res <= 1 ? (done_ok && !done_fail) : 1'b1, res == 0 ? "R4 ok first pair" : "R5 ok after recheck",
          {done_ok, done_fail}, 2);
    check(res == 2 ? (done_fail && !done_ok) : 1'b1, "R6 fail outcome", {done_ok, done_fail}, 1);
    check(nread - r0 == k_end - k0, "R3 read count", nread - r0, k_end - k0);
    check(nwrite - w0 == (res == 2 ? 1 : 0), "R6 write count", nwrite - w0, res == 2 ? 1 : 0);
    if (res == 2) check(last_wdata == 8'hF0 && last_waddr == RS_A, "R6 reset write",
                        last_wdata, 8'hF0);
    check(nbad == b0, "R9 address", nbad - b0, 0);
    @(negedge clk);
    check(!done_ok && !done_fail && !busy, "R8 one-cycle pulse", {done_ok, done_fail}, 0);
  endtask

  task automatic full_run(input int pat, input bit sel, input bit extra_start);
    int k_end, k2;
    bit yld = pat[7];
    @(negedge clk);
    cur_pat = pat; bit_sel = sel; run_base = nread;
    one_poll(pat, sel, 0, yld, extra_start, k_end);
    if (yielded) begin
      one_poll(pat, sel, k_end, 1'b0, 1'b0, k2);
      check(!yielded, "R7 yielded cleared by start", yielded, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && !req_valid && !rsp_ready && !done_ok && !done_fail && !yielded,
          "R1 reset state", {busy, req_valid, rsp_ready, done_ok, done_fail, yielded}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !req_valid, "R1 idle after reset", busy, 0);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 256; p++)
        full_run(p, s[0], 1'b0);
    for (int p = 0; p < 256; p += 37)
      full_run(p, 1'b0, 1'b1);   // R2 start while busy ignored
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule